// File: doc/BRIEF.md
# Synchronous Memory Card Protocol Engine

This block is the card end of a three-wire synchronous memory card link. A host drives a card clock line and a card reset line; the card answers on a single open-drain data line. Inside sits a 256-bit array addressed one bit at a time. A bit counter steps on each rising card clock and the addressed bit is presented on the data line at each falling card clock. There are no command bytes: programming is requested by the pattern of the two host lines. A reset pulse while the card clock is low arms the block, and the following rising card clock starts clearing the addressed bit instead of advancing. A second armed rising edge straight after a finished clear turns into setting all eight bits of the containing byte.

Both card lines are sampled by the chip's system clock, and all state is held in that domain. A programming run lasts a fixed number of system clock cycles, standing in for the cell programming time. Which addresses may be read, cleared or byte-set is decided by a separate protection block: this engine exports its current bit address and obeys three permission inputs. The lowest sixteen bits are never programmed, whatever the protection block says.

Top module: `mcard_engine`

## Requirements
- R1: After system reset the bit address is 0 and the data line is released (io_oe = 0); every array bit resets to 1.
- R2: A rising card clock with card reset low and the block not armed (or armed at an address below 16) increments the bit address by one, wrapping from 255 to 0, and disarms the block.
- R3: On a falling card clock, and on a falling card reset, the data line shows the bit at the current address: io_oe = 1 exactly when that bit is 0 and allow_read is 1; an unreadable bit leaves the line released.
- R4: A rising card clock with card reset high clears the bit address to 0 and disarms the block.
- R5: Card reset high while card clock is low arms the block; the next rising card clock at an address of 16 or more starts a programming run of PROG_CYCLES system cycles and leaves the address unchanged.
- R6: A plain programming run clears the addressed bit to 0 if allow_write is 1 at its end; the bit is shown on the data line once the run has ended and the card clock is low, even if the card clock fell early.
- R7: When the previous operation was a finished clear run with no address step or address clear since, an armed rising card clock starts a byte-set run instead, which sets all 8 bits of the byte holding the current address (address bits 7:3 select the byte) if allow_erase is 1 at its end; it does not chain further.
- R8: A clear run with allow_write low, or a byte-set run with allow_erase low, leaves the array unchanged.
- R9: The arming has no effect at addresses 0 to 15: the rising edge steps the address as in R2 and no bit changes.
- R10: While a programming run is in progress, neither the address nor the data line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| card_clk | input | 1 | Card clock from the host |
| card_rst | input | 1 | Card reset / arm line from the host |
| allow_read | input | 1 | Protection: current address may be shown |
| allow_write | input | 1 | Protection: current address may be cleared |
| allow_erase | input | 1 | Protection: current byte may be set |
| io_oe | output | 1 | Open-drain pull-down enable for the data line |
| prot_addr | output | 8 | Current bit address, to the protection block |

## Verification
A change on a card line is registered once, edge-detected, and acted on at the next system edge, so address and data-line results are due two system cycles after the line changes; the bench waits four system cycles after every line change before sampling on the falling system edge. A programming run finishes PROG_CYCLES system cycles after it starts, so the bench holds the card clock high (or waits after an early fall) for PROG_CYCLES plus six cycles before it samples the data line. Every sample compares against a bench model of address, arming, chaining and array contents driven by the same line events.

// File: rtl/mcard_pkg.sv
package mcard_pkg;
    typedef enum logic [1:0] {
        ST_READ  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2,
        ST_HOLD  = 2'd3
    } mc_state_t;
endpackage

// File: rtl/mcard_edge_sync.sv
module mcard_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic card_clk,
    input  logic card_rst,
    output logic clk_lvl,
    output logic rst_lvl,
    output logic clk_rise,
    output logic clk_fall,
    output logic rst_fall
);
    logic [1:0] ck_q;
    logic [1:0] rs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_q <= 2'b00;
            rs_q <= 2'b00;
        end else begin
            ck_q <= {ck_q[0], card_clk};
            rs_q <= {rs_q[0], card_rst};
        end
    end

    assign clk_lvl  = ck_q[0];
    assign rst_lvl  = rs_q[0];
    assign clk_rise = ck_q[0] & ~ck_q[1];
    assign clk_fall = ~ck_q[0] & ck_q[1];
    assign rst_fall = ~rs_q[0] & rs_q[1];
endmodule

// File: rtl/mcard_busy_timer.sv
module mcard_busy_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/mcard_bit_array.sv
module mcard_bit_array #(
    parameter int N_BITS = 256,
    parameter int AW     = $clog2(N_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          clr_bit,
    input  logic          set_byte,
    output logic          rd_bit
);
    localparam int BYTE_W = 3;
    logic [N_BITS-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '1;
        end else if (clr_bit) begin
            bits_q[addr] <= 1'b0;
        end else if (set_byte) begin
            for (int i = 0; i < (1 << BYTE_W); i++) begin
                bits_q[{addr[AW-1:BYTE_W], BYTE_W'(i)}] <= 1'b1;
            end
        end
    end

    assign rd_bit = bits_q[addr];
endmodule

// File: rtl/mcard_engine.sv
module mcard_engine
    import mcard_pkg::*;
#(
    parameter int N_BITS      = 256,
    parameter int MFR_BITS    = 16,
    parameter int PROG_CYCLES = 20,
    localparam int AW         = $clog2(N_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          card_clk,
    input  logic          card_rst,
    input  logic          allow_read,
    input  logic          allow_write,
    input  logic          allow_erase,
    output logic          io_oe,
    output logic [AW-1:0] prot_addr
);
    mc_state_t     state_q, state_d;
    logic          clk_lvl, rst_lvl, clk_rise, clk_fall, rst_fall;
    logic          armed_q, chain_q, op_set_q, io_q;
    logic [AW-1:0] addr_q;
    logic          tmr_start, tmr_done, rd_bit;
    logic          in_user;

    mcard_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .card_rst(card_rst),
        .clk_lvl(clk_lvl), .rst_lvl(rst_lvl), .clk_rise(clk_rise),
        .clk_fall(clk_fall), .rst_fall(rst_fall)
    );

    mcard_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .done(tmr_done)
    );

    mcard_bit_array #(.N_BITS(N_BITS), .AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n), .addr(addr_q),
        .clr_bit(state_q == ST_PROG && tmr_done && allow_write),
        .set_byte(state_q == ST_ERASE && tmr_done && allow_erase),
        .rd_bit(rd_bit)
    );

    assign in_user = (addr_q >= AW'(MFR_BITS));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READ;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READ:  if (clk_rise && !rst_lvl && armed_q && in_user)
                          state_d = chain_q ? ST_ERASE : ST_PROG;
            ST_PROG:  if (tmr_done) state_d = ST_HOLD;
            ST_ERASE: if (tmr_done) state_d = ST_HOLD;
            ST_HOLD:  if (!clk_lvl) state_d = ST_READ;
        endcase
    end

    assign tmr_start = (state_q == ST_READ) && (state_d != ST_READ);

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            armed_q  <= 1'b0;
            chain_q  <= 1'b0;
            op_set_q <= 1'b0;
            io_q     <= 1'b1;
        end else begin
            unique case (state_q)
                ST_READ: begin
                    if (clk_rise) begin
                        if (rst_lvl) begin
                            addr_q  <= '0;
                            armed_q <= 1'b0;
                            chain_q <= 1'b0;
                        end else if (armed_q && in_user) begin
                            op_set_q <= chain_q;
                        end else begin
                            addr_q  <= addr_q + 1'b1;
                            armed_q <= 1'b0;
                            chain_q <= 1'b0;
                        end
                    end else begin
                        if (clk_fall || rst_fall)
                            io_q <= allow_read ? rd_bit : 1'b1;
                        if (rst_lvl && !clk_lvl)
                            armed_q <= 1'b1;
                    end
                end
                ST_PROG, ST_ERASE: begin
                end
                ST_HOLD: begin
                    if (!clk_lvl) begin
                        io_q    <= allow_read ? rd_bit : 1'b1;
                        armed_q <= 1'b0;
                        chain_q <= ~op_set_q;
                    end
                end
            endcase
        end
    end

    assign io_oe     = ~io_q;
    assign prot_addr = addr_q;
endmodule

// File: rtl/mcard_engine_chk.sv
module mcard_engine_chk
    import mcard_pkg::*;
#(
    parameter int MFR_BITS = 16,
    parameter int AW       = 8
) (
    input logic          clk,
    input logic          rst_n,
    input mc_state_t     st,
    input logic          clk_rise,
    input logic          rst_lvl,
    input logic          io_oe,
    input logic [AW-1:0] prot_addr
);
    AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && clk_rise && rst_lvl) |=> (prot_addr == '0)); // R4

    AST_BUSY_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_READ) |=> $stable(prot_addr)); // R10

    AST_BUSY_IO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG || st == ST_ERASE) |=> $stable(io_oe)); // R10

    AST_MFR_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG || st == ST_ERASE) |-> (prot_addr >= AW'(MFR_BITS))); // R9
endmodule

bind mcard_engine mcard_engine_chk #(.MFR_BITS(MFR_BITS), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(state_q), .clk_rise(clk_rise),
    .rst_lvl(rst_lvl), .io_oe(io_oe), .prot_addr(prot_addr)
);

// File: tb/mcard_engine_bench.sv
module mcard_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 256;
    localparam int PROG = 20;
    localparam int MFR  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_clk = 1'b0;
    logic card_rst = 1'b0;
    logic io_oe;
    logic [7:0] prot_addr;
    logic allow_read, allow_write, allow_erase;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model
    bit   m_mem [NB];
    int   m_addr = 0;
    bit   m_armed = 0;
    bit   m_chain = 0;
    bit   m_pend = 0;
    bit   m_pend_set = 0;

    function automatic bit rd_ok(int a);  return !(a >= 80 && a < 104); endfunction
    function automatic bit wr_ok(int a);  return !(a >= 64 && a < 72);  endfunction
    function automatic bit er_ok(int a);  return !(a >= 16 && a < 64);  endfunction

    assign allow_read  = rd_ok(int'(prot_addr));
    assign allow_write = wr_ok(int'(prot_addr));
    assign allow_erase = er_ok(int'(prot_addr));

    always #(CLK_PERIOD/2) clk = ~clk;

    mcard_engine #(.N_BITS(NB), .MFR_BITS(MFR), .PROG_CYCLES(PROG)) u_mcard_engine (
        .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .card_rst(card_rst),
        .allow_read(allow_read), .allow_write(allow_write), .allow_erase(allow_erase),
        .io_oe(io_oe), .prot_addr(prot_addr)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_addr(string r);
        n_chk++;
        if (int'(prot_addr) != m_addr) begin
            n_bad++;
            $display("FAIL %s addr actual=%0d expected=%0d", r, prot_addr, m_addr);
        end
    endtask

    task automatic check_io(string r);
        bit exp;
        exp = rd_ok(m_addr) ? !m_mem[m_addr] : 1'b0;
        n_chk++;
        if (io_oe !== exp) begin
            n_bad++;
            $display("FAIL %s io_oe at %0d actual=%b expected=%b", r, m_addr, io_oe, exp);
        end
    endtask

    task automatic do_rise(string r);
        card_clk = 1'b1;
        tick(4);
        if (card_rst) begin
            m_addr = 0; m_armed = 0; m_chain = 0;
        end else if (m_armed && m_addr >= MFR) begin
            m_pend = 1; m_pend_set = m_chain;
        end else begin
            m_addr = (m_addr + 1) % NB; m_armed = 0; m_chain = 0;
        end
        check_addr(r);
    endtask

    task automatic do_fall(string r);
        card_clk = 1'b0;
        tick(4);
        if (m_pend) begin
            tick(PROG + 6);
            if (m_pend_set) begin
                if (er_ok(m_addr))
                    for (int i = 0; i < 8; i++) m_mem[(m_addr & ~7) + i] = 1'b1;
            end else if (wr_ok(m_addr)) begin
                m_mem[m_addr] = 1'b0;
            end
            m_chain = !m_pend_set;
            m_armed = 0;
            m_pend = 0;
        end
        check_io(r);
    endtask

    task automatic rst_pulse(string r);
        card_rst = 1'b1;
        tick(4);
        m_armed = 1;
        card_rst = 1'b0;
        tick(4);
        check_io(r);
    endtask

    task automatic addr_reset();
        card_rst = 1'b1;
        tick(4);
        m_armed = 1;
        do_rise("R4");
        card_rst = 1'b0;
        tick(4);
        check_io("R4");
        do_fall("R3");
    endtask

    task automatic step(string r);
        do_rise(r);
        do_fall(r);
    endtask

    task automatic goto_addr(int a);
        addr_reset();
        for (int i = 0; i < a; i++) step("R2");
    endtask

    task automatic prog_op(string r, bit early);
        rst_pulse("R3");
        do_rise(r);
        if (!early) tick(PROG + 6);
        else        tick(3);
        do_fall(r);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int r;
        for (int i = 0; i < NB; i++) m_mem[i] = 1'b1;
        void'($urandom(32'h1357_2468));
        tick(3);
        // R1: reset state
        check_addr("R1");
        check_io("R1");
        rst_n = 1'b1;
        tick(2);
        check_addr("R1");
        check_io("R1");
        // power-up sequence
        addr_reset();
        step("R2");
        // R9: arming inside the manufacturer bits only steps
        goto_addr(5);
        prog_op("R9", 0);
        goto_addr(5);
        do_fall("R9");
        // R5/R6: clear bit 130, then chained set of its byte (R7)
        goto_addr(128);
        prog_op("R5", 0);
        step("R6");
        prog_op("R6", 0);
        step("R6");
        prog_op("R6", 1);
        prog_op("R7", 0);
        prog_op("R7", 0);
        // R8: clear refused at 66, byte set refused at 20
        goto_addr(66);
        prog_op("R8", 0);
        goto_addr(20);
        prog_op("R6", 0);
        prog_op("R8", 0);
        // R3: unreadable region
        goto_addr(85);
        prog_op("R3", 0);
        // R2: wrap past 255
        goto_addr(250);
        for (int i = 0; i < 10; i++) step("R2");
        // random mix
        for (int k = 0; k < 500; k++) begin
            r = int'($urandom % 16);
            if (r < 3)       prog_op("R7", ($urandom % 4) == 0);
            else if (r == 3) addr_reset();
            else if (r == 4) rst_pulse("R3");
            else             step("R2");
        end
        summary();
    end
endmodule